// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block is the timekeeping core of a real-time clock. Seven packed-BCD byte registers hold the seconds, minutes, hours, day of month, month, two-digit year and weekday. A one-cycle enable at 32768 Hz (`tick_i`) drives a sub-second prescaler. Each time the prescaler completes a full second, the calendar advances and carries ripple up through the fields, following month lengths and leap years.

Software reaches the block through a byte-wide register port. The port has a write strobe, an address, write data and a combinational read-data output. Besides the time fields there is a control register, which holds the run bit and some plain storage bits. There is also a status register. It reports the run state, a busy flag that rises shortly before each seconds update, sticky rollover flags and a power-up flag. Software waits for busy to clear and then has most of a second to read or rewrite the fields. Write protection comes from an external lock block, through `wr_allow_i`.

Register byte offsets: seconds 0x00, minutes 0x04, hours 0x08, day 0x0C, month 0x10, year 0x14, weekday 0x18, control 0x40, status 0x44. Any other offset reads 0 and ignores writes.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00 and weekday 0x00. Control reads 0x00 and status reads 0x80, with only the power-up flag (bit 7) set.
- R2: While control bit 0 is 1, the seconds field advances by one each time TICKS_PER_SEC ticks have been counted. While it is 0, no field changes on ticks. Status bit 1 reads the run bit.
- R3: Seconds and minutes roll from 0x59 to 0x00 and hours from 0x23 to 0x00, each carrying into the next field. On a day carry the weekday advances, with 0x06 wrapping to 0x00.
- R4: The day rolls to 0x01 after the last day of the month. That is 31 for months 1, 3, 5, 7, 8, 10 and 12, and 30 for 4, 6, 9 and 11. February has 29 days when the binary year is divisible by 4, otherwise 28. Month 0x12 rolls to 0x01 and year 0x99 rolls to 0x00.
- R5: Status bit 0 (busy) is 1 while running and the prescaler is in its last BUSY_LEAD ticks of a second. It is 0 from the cycle after the seconds update.
- R6: Status bits 2, 3, 4 and 5 are set by a second, minute, hour and day rollover respectively. They stay set until cleared.
- R7: Writing 1 to status bits 2 to 5 or bit 7 clears them, and writing 0 has no effect. If a rollover sets a bit in the same cycle as a clear, the bit stays set.
- R8: A field write stores the data ANDed with the field mask: seconds 0x7F, minutes 0x7F, hours 0x3F, day 0x3F, month 0x1F, year 0xFF, weekday 0x07. The written field wins over an update in the same cycle, and the other fields still advance.
- R9: A seconds write restarts the prescaler, so the next update comes a full TICKS_PER_SEC ticks later. A seconds write in an update cycle drops that whole update, including its events.
- R10: While `wr_allow_i` is 0, every write is ignored, including control writes and status clears.
- R11: Control keeps bits 0, 2, 3 and 7, and its other bits read 0. Unmapped or misaligned offsets read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle 32768 Hz enable |
| wr_allow_i | input | 1 | Write permission from the lock block |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |

## Verification
Two kinds of software access can land in the very cycle the prescaler completes a second. The first is a write-one clear of the second-event flag, which must leave the flag set. The second is a field write: a minutes write must override that field while seconds still advance, and a seconds write must cancel the update. The bench provokes each case by stepping the prescaler to its last count and then issuing the write with `tick_i` high in the same cycle. It judges the result by reading back status and fields once the tick has been taken. A continuous one-hour sweep across a year boundary and a per-month last-day sweep over several years are compared against an arithmetic calendar model in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef logic [7:0] bcd_t;

  localparam int NUM_FIELDS = 7;
  localparam int I_SEC  = 0;
  localparam int I_MIN  = 1;
  localparam int I_HOUR = 2;
  localparam int I_DAY  = 3;
  localparam int I_MON  = 4;
  localparam int I_YEAR = 5;
  localparam int I_WDAY = 6;

  localparam logic [7:0] OFS_CTRL  = 8'h40;
  localparam logic [7:0] OFS_STAT  = 8'h44;
  localparam logic [7:0] CTRL_MASK = 8'h8D;
  localparam int CTRL_RUN     = 0;
  localparam int STAT_BUSY    = 0;
  localparam int STAT_RUN     = 1;
  localparam int STAT_EVT_LSB = 2;
  localparam int STAT_PWR     = 7;

  function automatic bcd_t field_mask(input int idx);
    case (idx)
      I_SEC, I_MIN:          return 8'h7F;
      I_HOUR, I_DAY:         return 8'h3F;
      I_MON:                 return 8'h1F;
      I_WDAY:                return 8'h07;
      default:               return 8'hFF;
    endcase
  endfunction

  function automatic bcd_t field_reset(input int idx);
    return (idx == I_DAY || idx == I_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic bcd_t bcd_inc(input bcd_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic bcd_t last_day(input bcd_t mon, input bcd_t yr);
    logic [7:0] yb;
    yb = 8'(yr[7:4]) * 8'd10 + 8'(yr[3:0]);
    case (mon)
      8'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int BUSY_LEAD     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic restart_i,
  output logic sec_pulse_o,
  output logic busy_o
);
  localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] LAST      = CNT_W'(TICKS_PER_SEC - 1);
  localparam logic [CNT_W-1:0] BUSY_FROM = CNT_W'(TICKS_PER_SEC - BUSY_LEAD);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign sec_pulse_o = run_i & tick_i & ~restart_i & (cnt_q == LAST);
  assign busy_o      = run_i & (cnt_q >= BUSY_FROM);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           upd_i,
  input  logic [NUM_FIELDS-1:0]          wr_fld_i,
  input  bcd_t                           wdata_i,
  output logic [NUM_FIELDS-1:0][7:0]     fld_o,
  output logic [3:0]                     carry_o
);
  bcd_t fld_q [NUM_FIELDS];
  bcd_t nxt   [NUM_FIELDS];
  logic c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++) nxt[i] = fld_q[i];
    c_min = upd_i & (fld_q[I_SEC] >= 8'h59);
    c_hr  = c_min & (fld_q[I_MIN] >= 8'h59);
    c_day = c_hr  & (fld_q[I_HOUR] >= 8'h23);
    c_mon = c_day & (fld_q[I_DAY] >= last_day(fld_q[I_MON], fld_q[I_YEAR]));
    c_yr  = c_mon & (fld_q[I_MON] >= 8'h12);
    if (upd_i) nxt[I_SEC]  = c_min ? 8'h00 : bcd_inc(fld_q[I_SEC]);
    if (c_min) nxt[I_MIN]  = c_hr  ? 8'h00 : bcd_inc(fld_q[I_MIN]);
    if (c_hr)  nxt[I_HOUR] = c_day ? 8'h00 : bcd_inc(fld_q[I_HOUR]);
    if (c_day) begin
      nxt[I_DAY]  = c_mon ? 8'h01 : bcd_inc(fld_q[I_DAY]);
      nxt[I_WDAY] = (fld_q[I_WDAY] >= 8'h06) ? 8'h00 : fld_q[I_WDAY] + 8'h01;
    end
    if (c_mon) nxt[I_MON]  = c_yr ? 8'h01 : bcd_inc(fld_q[I_MON]);
    if (c_yr)  nxt[I_YEAR] = (fld_q[I_YEAR] >= 8'h99) ? 8'h00 : bcd_inc(fld_q[I_YEAR]);
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          fld_q[g] <= field_reset(g);
      else if (wr_fld_i[g]) fld_q[g] <= wdata_i & field_mask(g);
      else                  fld_q[g] <= nxt[g];
    end
    assign fld_o[g] = fld_q[g];
  end

  assign carry_o = {c_day, c_hr, c_min, upd_i};
endmodule

// File: rtl/rtc_ctrl_status.sv
module rtc_ctrl_status
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_ctrl_i,
  input  logic       wr_stat_i,
  input  bcd_t       wdata_i,
  input  logic [3:0] evt_i,
  input  logic       busy_i,
  output logic [7:0] ctrl_o,
  output logic [7:0] stat_o
);
  logic [7:0] ctrl_q;
  logic [3:0] evt_q;
  logic       pwr_q;
  logic [3:0] evt_clr;

  assign evt_clr = wr_stat_i ? wdata_i[STAT_EVT_LSB +: 4] : 4'h0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 8'h00;
      evt_q  <= 4'h0;
      pwr_q  <= 1'b1;
    end else begin
      if (wr_ctrl_i) ctrl_q <= wdata_i & CTRL_MASK;
      evt_q <= (evt_q & ~evt_clr) | evt_i;
      if (wr_stat_i && wdata_i[STAT_PWR]) pwr_q <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;
  assign stat_o = {pwr_q, 1'b0, evt_q, ctrl_q[CTRL_RUN], busy_i};
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int BUSY_LEAD     = 2,
  parameter int ADDR_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_allow_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  logic                       wr, fld_hit;
  logic [2:0]                 fld_idx;
  logic [NUM_FIELDS-1:0]      wr_fld;
  logic                       wr_ctrl, wr_stat, wr_sec;
  logic                       upd, busy, run;
  logic [NUM_FIELDS-1:0][7:0] fld;
  logic [3:0]                 carry, evt_q;
  logic [7:0]                 ctrl_q, stat_q, sec_q;

  assign wr      = bus_we_i & wr_allow_i;
  assign fld_idx = bus_addr_i[4:2];
  assign fld_hit = (bus_addr_i[ADDR_W-1:5] == '0) && (bus_addr_i[1:0] == 2'b00)
                   && (int'(fld_idx) < NUM_FIELDS);

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_wdec
    assign wr_fld[g] = wr & fld_hit & (int'(fld_idx) == g);
  end

  assign wr_ctrl = wr & (bus_addr_i == A_CTRL);
  assign wr_stat = wr & (bus_addr_i == A_STAT);
  assign wr_sec  = wr_fld[I_SEC];
  assign run     = ctrl_q[CTRL_RUN];

  rtc_prescaler #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .BUSY_LEAD    (BUSY_LEAD)
  ) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .run_i      (run),
    .restart_i  (wr_sec),
    .sec_pulse_o(upd),
    .busy_o     (busy)
  );

  rtc_calendar u_cal (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (upd),
    .wr_fld_i(wr_fld),
    .wdata_i (bus_wdata_i),
    .fld_o   (fld),
    .carry_o (carry)
  );

  rtc_ctrl_status u_cs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_ctrl_i(wr_ctrl),
    .wr_stat_i(wr_stat),
    .wdata_i  (bus_wdata_i),
    .evt_i    (carry),
    .busy_i   (busy),
    .ctrl_o   (ctrl_q),
    .stat_o   (stat_q)
  );

  assign evt_q = stat_q[STAT_EVT_LSB +: 4];
  assign sec_q = fld[I_SEC];

  always_comb begin
    bus_rdata_o = 8'h00;
    if (fld_hit)                    bus_rdata_o = fld[fld_idx];
    else if (bus_addr_i == A_CTRL)  bus_rdata_o = ctrl_q;
    else if (bus_addr_i == A_STAT)  bus_rdata_o = stat_q;
  end
endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       upd,
  input logic       busy,
  input logic       run,
  input logic       wr_sec,
  input logic       wr_ctrl,
  input logic [7:0] sec_q,
  input logic [7:0] ctrl_q,
  input logic [3:0] evt_q
);
  p_frozen_when_stopped_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !wr_sec) |=> $stable(sec_q));

  p_sec_wraps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && sec_q == 8'h59) |=> (sec_q == 8'h00));

  p_busy_needs_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> ctrl_q[0]);

  p_busy_drops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> !busy);

  p_sec_event_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> evt_q[0]);

  p_no_update_on_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sec |-> !upd);

  p_ctrl_only_by_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl |=> $stable(ctrl_q));
endmodule

bind rtc_bcd_core rtc_bcd_core_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .upd    (upd),
  .busy   (busy),
  .run    (run),
  .wr_sec (wr_sec),
  .wr_ctrl(wr_ctrl),
  .sec_q  (sec_q),
  .ctrl_q (ctrl_q),
  .evt_q  (evt_q)
);

// File: tb/rtc_bcd_core_test.sv
module rtc_bcd_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int TPS  = 4;
  localparam int LEAD = 1;

  logic clk = 0, rst_n = 0, tick = 0, we = 0, allow = 1;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] rdata;

  int n_chk = 0, n_fail = 0;
  int ms, mm, mh, md, mmo, my, mw, mev;

  rtc_bcd_core #(.TICKS_PER_SEC(TPS), .BUSY_LEAD(LEAD), .ADDR_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_allow_i(allow),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] bcd(input int x);
    return 8'(((x / 10) << 4) | (x % 10));
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic tk);
    @(negedge clk);
    addr = a; wdata = d; we = 1; tick = tk;
    @(negedge clk);
    we = 0; tick = 0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin @(negedge clk); tick = 1; end
    @(negedge clk); tick = 0;
  endtask

  task automatic madv();
    ms++; mev |= 8'h04;
    if (ms == 60) begin
      ms = 0; mm++; mev |= 8'h08;
      if (mm == 60) begin
        mm = 0; mh++; mev |= 8'h10;
        if (mh == 24) begin
          mh = 0; mev |= 8'h20; mw = (mw + 1) % 7; md++;
          if (md > mdays(mmo, my)) begin
            md = 1; mmo++;
            if (mmo > 12) begin mmo = 1; my = (my + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic load_model();
    wr(8'h14, bcd(my), 0);  wr(8'h10, bcd(mmo), 0); wr(8'h0C, bcd(md), 0);
    wr(8'h18, bcd(mw), 0);  wr(8'h08, bcd(mh), 0);  wr(8'h04, bcd(mm), 0);
    wr(8'h00, bcd(ms), 0);
  endtask

  task automatic chk_fields(input string req);
    rdchk(req, 8'h00, bcd(ms));  rdchk(req, 8'h04, bcd(mm));
    rdchk(req, 8'h08, bcd(mh));  rdchk(req, 8'h0C, bcd(md));
    rdchk(req, 8'h10, bcd(mmo)); rdchk(req, 8'h14, bcd(my));
    rdchk(req, 8'h18, bcd(mw));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] masks [7];
    int ys [7];
    masks = '{8'h7F, 8'h7F, 8'h3F, 8'h3F, 8'h1F, 8'hFF, 8'h07};
    ys    = '{0, 1, 2, 3, 4, 98, 99};
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    ms = 0; mm = 0; mh = 0; md = 1; mmo = 1; my = 0; mw = 0;
    chk_fields("R1");
    rdchk("R1", 8'h40, 8'h00);
    rdchk("R1", 8'h44, 8'h80);

    // R11 control storage and unmapped reads
    wr(8'h40, 8'hFF, 0);
    rdchk("R11", 8'h40, 8'h8D);
    rdchk("R2", 8'h44, 8'h82);
    wr(8'h40, 8'h00, 0);
    rdchk("R11", 8'h1C, 8'h00);
    rdchk("R11", 8'h20, 8'h00);
    rdchk("R11", 8'h48, 8'h00);
    rdchk("R11", 8'h01, 8'h00);

    // R8 field masks
    for (int i = 0; i < 7; i++) wr(8'(i * 4), 8'hFF, 0);
    for (int i = 0; i < 7; i++) rdchk("R8", 8'(i * 4), masks[i]);

    // R10 writes blocked
    allow = 0;
    wr(8'h04, 8'h33, 0);
    wr(8'h44, 8'hFF, 0);
    wr(8'h40, 8'h01, 0);
    allow = 1;
    rdchk("R10", 8'h04, 8'h7F);
    rdchk("R10", 8'h44, 8'h80);
    rdchk("R10", 8'h40, 8'h00);

    // R7 write-one-to-clear of power-up flag
    wr(8'h44, 8'h00, 0);
    rdchk("R7", 8'h44, 8'h80);
    wr(8'h44, 8'h80, 0);
    rdchk("R7", 8'h44, 8'h00);

    // R3/R5/R6: one hour across a year boundary
    ms = 0; mm = 0; mh = 23; md = 31; mmo = 12; my = 23; mw = 6;
    load_model();
    wr(8'h40, 8'h01, 0);
    wr(8'h44, 8'h3C, 0);
    mev = 0;
    for (int k = 0; k < 3600; k++) begin
      ticks(TPS - LEAD - 1);
      rdchk("R5", 8'h44, 8'h02);
      ticks(LEAD);
      rdchk("R5", 8'h44, 8'h03);
      ticks(1);
      madv();
      chk_fields("R3");
      rdchk("R6", 8'h44, 8'(8'h02 | mev));
      wr(8'h44, 8'h3C, 0);
      mev = 0;
    end

    // R4 month ends and leap years
    for (int yi = 0; yi < 7; yi++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        ms = 59; mm = 59; mh = 23; mmo = mo; my = ys[yi]; mw = (mo + yi) % 7;
        md = mdays(mo, my);
        load_model();
        ticks(TPS);
        madv();
        chk_fields("R4");
        if (mo == 2) begin
          ms = 59; mm = 59; mh = 23; mmo = 2; my = ys[yi]; md = 28;
          load_model();
          ticks(TPS);
          madv();
          chk_fields("R4");
        end
      end
    end

    // R2 stopped counter
    wr(8'h44, 8'h3C, 0);
    wr(8'h40, 8'h00, 0);
    ticks(3 * TPS);
    chk_fields("R2");
    rdchk("R2", 8'h44, 8'h00);
    wr(8'h40, 8'h01, 0);

    // R9 prescaler restart on seconds write
    wr(8'h00, 8'h05, 0);
    ticks(2);
    wr(8'h00, 8'h10, 0);
    ticks(TPS - 1);
    rdchk("R9", 8'h00, 8'h10);
    ticks(1);
    rdchk("R9", 8'h00, 8'h11);
    ticks(TPS - 1);
    wr(8'h44, 8'h3C, 0);
    wr(8'h00, 8'h20, 1);
    rdchk("R9", 8'h00, 8'h20);
    rdchk("R9", 8'h44, 8'h02);
    ticks(TPS);
    rdchk("R9", 8'h00, 8'h21);

    // R7 clear colliding with set: set wins
    ticks(TPS - 1);
    wr(8'h44, 8'h04, 1);
    rdchk("R7", 8'h00, 8'h22);
    rdchk("R7", 8'h44, 8'h06);
    wr(8'h44, 8'h04, 0);
    rdchk("R7", 8'h44, 8'h02);

    // R8 field write colliding with update
    ticks(TPS - 1);
    wr(8'h04, 8'h45, 1);
    rdchk("R8", 8'h04, 8'h45);
    rdchk("R8", 8'h00, 8'h23);

    finish_run();
  end
endmodule